// File: doc/BRIEF.md
# Multi-mode 24-bit event timer

This block is one programmable down-counting channel with a 24-bit reload value. Software reaches it through a small register bus: the 24-bit value moves through one 16-bit data port. A selector field in a select/output register chooses whether a data access reaches the low 16 bits or the high 8 bits. The same select register also drives four general-purpose output pins, so each write to it updates those pins as well.

The channel counts ticks from one of four single-cycle strobe inputs: a free-running oscillator tick, the output of a neighbouring timer, end-of-conversion pulses or end-of-scan pulses. A gate bit in the control register starts counting. A 2-bit mode code selects a periodic rate mode or one of three one-shot variants. A function field selects timer, event counter or watchdog behaviour. When the count reaches terminal count, a pending flag is latched. That flag raises the interrupt line when interrupts are enabled, and reading the select register clears it.

Top module: `evt_timer24`

## Requirements
- R1: After reset the status word reads 0, the count reads 0, and `tc_out`, `irq` and `dout` are all 0.
- R2: A write to the select register (address 3) stores wdata[7:0]. `dout` follows bits 7:4, and a read of address 3 returns the stored byte.
- R3: With selector (select bits 3:0) equal to 2, a data-port (address 4) write sets reload[15:0]. With selector 3, the write sets reload[23:16] from wdata[7:0]. A rising edge of the gate (control register, address 0, bit 14) loads the reload value into the count. A data-port read returns count[15:0] for selector 2 and count[23:16] for selector 3.
- R4: A reload value of 0 or 1 loads as 2.
- R5: Mode code 1 (mode register at address 1, bits 5:4) is rate mode. The tick that finds the count at 1 is a terminal count. That tick reloads the count, pulses `tc_out` for one cycle, and counting continues. The period is the reload value in ticks.
- R6: With mode code 0, the terminal-count tick leaves the count at 0 and stops counting. `tc_out` then stays high until the next load.
- R7: Mode codes 2 and 3 are one-shot. On terminal count the count stops at 0 and `tc_out` pulses for one cycle. With code 2, a high-half data write while the gate is set restarts the count from the reload value. With code 3, only a new gate rising edge restarts it.
- R8: Configuration register (address 2) bits 7:6 select the tick source: 0 `osc_tick`, 1 `t1_out`, 2 `eoc_pulse`, 3 `eos_pulse`. Strobes on the other three inputs leave the count unchanged.
- R9: While the gate is 0, ticks leave the count unchanged.
- R10: Terminal count sets the pending flag, which reads as status (address 5) bit 12. `irq` is high when the flag is set and configuration bit 2 is 1.
- R11: A read of the select register clears the pending flag. If a terminal count happens in the same cycle as that read, the flag stays set.
- R12: A low-half count read captures the high half of the count. A later high-half read returns that captured value, even if the count has moved since the low-half read.
- R13: With function code 2 (configuration bits 5:4), any data-port write made while the channel is counting restarts the count from the reload value, using the value just written. Function codes 0 and 1 count identically, and for them such a write does not restart the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (applies read side effects at the clock edge) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| osc_tick | input | 1 | Oscillator tick strobe |
| t1_out | input | 1 | Upstream timer output strobe |
| eoc_pulse | input | 1 | End-of-conversion strobe |
| eos_pulse | input | 1 | End-of-scan strobe |
| tc_out | output | 1 | Terminal-count output |
| irq | output | 1 | Interrupt request |
| dout | output | 4 | General-purpose outputs from the select register |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume that each tick input is a single-cycle strobe that the clock samples. The count is therefore judged per sampled tick, not per input edge. The stimulus keeps to these rules: every bus access and every tick is issued by a task that holds the strobe for exactly one clock. The tasks only overlap a read with a tick in the one test aimed at the simultaneous set-and-clear case. Random runs draw reload values below 40 and tick counts below 45, so terminal counts occur often in every mode.

// File: rtl/tmr24_pkg.sv
// Package: shared encodings for the 24-bit event timer.
// Assumes: register addresses and field codes are fixed by software.
package tmr24_pkg;

    typedef enum logic [1:0] {
        CM_STOP0  = 2'd0,   // count to zero and hold output high
        CM_RATE   = 2'd1,   // periodic reload
        CM_SWSTRB = 2'd2,   // one-shot, restart by high-half write
        CM_HWSTRB = 2'd3    // one-shot, restart by gate edge only
    } cmode_e;

    typedef enum logic [1:0] {
        FN_TIMER = 2'd0,
        FN_COUNT = 2'd1,
        FN_WDOG  = 2'd2,
        FN_RSVD  = 2'd3
    } func_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMODE = 3'd1;
    localparam logic [2:0] A_CFG   = 3'd2;
    localparam logic [2:0] A_SEL   = 3'd3;
    localparam logic [2:0] A_DATA  = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

endpackage

// File: rtl/tmr24_clksel.sv
// Module: picks the tick strobe that drives the counter.
// Assumes: every source is a single-cycle strobe synchronous to clk.
module tmr24_clksel #(
    parameter int NSRC = 4,
    localparam int SW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] src,
    input  logic [SW-1:0]   sel,
    output logic            tick
);
    // Select one strobe by index.
    always_comb begin
        tick = src[sel];
    end
endmodule

// File: rtl/tmr24_core.sv
// Module: 24-bit down counter with four counting modes.
// Assumes: reload and mode are stable while counting; restart requests
// arrive one cycle after the bus write so the new reload is visible.
module tmr24_core
    import tmr24_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gate,
    input  cmode_e        cmode,
    input  func_e         func,
    input  logic [CW-1:0] reload,
    input  logic          hi_wr,
    input  logic          data_wr,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          tc_evt,
    output logic          tc_out
);
    localparam logic [CW-1:0] MIN_LOAD = CW'(2);
    localparam logic [CW-1:0] ONE      = CW'(1);

    logic          gate_q;
    logic          req_q;
    logic          restart;
    logic [CW-1:0] reload_eff;

    // Clamp small reloads to the minimum usable value.
    always_comb begin
        reload_eff = (reload < MIN_LOAD) ? MIN_LOAD : reload;
    end

    // Restart on gate rise or on a queued strobe/kick.
    always_comb begin
        restart = (gate & ~gate_q) | (gate & req_q);
        tc_evt  = tick & running & gate & (cnt == ONE) & ~restart;
    end

    // Remember gate and queue strobe or watchdog kick requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            gate_q <= gate;
            req_q  <= gate & ((hi_wr & (cmode == CM_SWSTRB)) |
                              (data_wr & running & (func == FN_WDOG)));
        end
    end

    // Count ticks, handle terminal count per mode, drive output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            tc_out  <= 1'b0;
        end else begin
            if (cmode != CM_STOP0) tc_out <= 1'b0;
            if (restart) begin
                cnt     <= reload_eff;
                running <= 1'b1;
                tc_out  <= 1'b0;
            end else if (tick && running && gate) begin
                if (cnt == ONE) begin
                    tc_out <= 1'b1;
                    if (cmode == CM_RATE) begin
                        cnt <= reload_eff;
                    end else begin
                        cnt     <= '0;
                        running <= 1'b0;
                    end
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    p_count_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0));
    p_rate_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && cmode == CM_RATE) |=> (running && cnt >= MIN_LOAD));
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && cmode != CM_RATE) |=> (!running && tc_out));
    p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate) |=> $stable(cnt));
endmodule

// File: rtl/tmr24_regs.sv
// Module: register file, split data port, snapshot and pending flag.
// Assumes: bus_wr and bus_rd are never high together; read data is
// combinational and read side effects happen at the clock edge.
module tmr24_regs
    import tmr24_pkg::*;
#(
    parameter int CW        = 24,
    parameter int DW        = 16,
    parameter int TIMER_IDX = 2,
    localparam int HW       = CW - DW,
    localparam int GATE_BIT = 12 + TIMER_IDX,
    localparam int MODE_LSB = 2 * TIMER_IDX,
    localparam int PEND_BIT = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] cnt,
    input  logic          running,
    input  logic          tc_evt,
    output logic          gate,
    output cmode_e        cmode,
    output logic [1:0]    clk_sel,
    output func_e         func,
    output logic [CW-1:0] reload,
    output logic          hi_wr,
    output logic          data_wr,
    output logic          irq,
    output logic [3:0]    dout
);
    localparam logic [3:0] SEL_LO = 4'(TIMER_IDX);
    localparam logic [3:0] SEL_HI = 4'(TIMER_IDX + 1);

    logic          ien;
    logic [7:0]    sel_r;
    logic [HW-1:0] snap_hi;
    logic          pend;
    logic          sel_lo, sel_hi;

    always_comb begin
        sel_lo  = (sel_r[3:0] == SEL_LO);
        sel_hi  = (sel_r[3:0] == SEL_HI);
        data_wr = bus_wr && (bus_addr == A_DATA);
        hi_wr   = data_wr && sel_hi;
        dout    = sel_r[7:4];
        irq     = pend & ien;
    end

    // Register writes from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate    <= 1'b0;
            cmode   <= CM_STOP0;
            clk_sel <= 2'd0;
            func    <= FN_TIMER;
            ien     <= 1'b0;
            sel_r   <= '0;
            reload  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  gate <= bus_wdata[GATE_BIT];
                A_CMODE: cmode <= cmode_e'(bus_wdata[MODE_LSB +: 2]);
                A_CFG: begin
                    clk_sel <= bus_wdata[7:6];
                    func    <= func_e'(bus_wdata[5:4]);
                    ien     <= bus_wdata[2];
                end
                A_SEL:   sel_r <= bus_wdata[7:0];
                A_DATA: begin
                    if (sel_lo) reload[DW-1:0] <= bus_wdata;
                    if (sel_hi) reload[CW-1:DW] <= bus_wdata[HW-1:0];
                end
                default: ;
            endcase
        end
    end

    // Capture the high half on a low-half count read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi <= '0;
        end else if (bus_rd && bus_addr == A_DATA && sel_lo) begin
            snap_hi <= cnt[CW-1:DW];
        end
    end

    // Latch terminal count; select-register read clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (tc_evt) begin
            pend <= 1'b1;
        end else if (bus_rd && bus_addr == A_SEL) begin
            pend <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata[GATE_BIT] = gate;
            A_CMODE: bus_rdata[MODE_LSB +: 2] = cmode;
            A_CFG:   bus_rdata = {8'b0, clk_sel, func, 1'b0, ien, 2'b0};
            A_SEL:   bus_rdata = {8'b0, sel_r};
            A_DATA: begin
                if (sel_lo) bus_rdata = cnt[DW-1:0];
                if (sel_hi) bus_rdata = {{(DW-HW){1'b0}}, snap_hi};
            end
            A_STAT: begin
                bus_rdata[PEND_BIT] = pend;
                bus_rdata[0]        = running;
            end
            default: ;
        endcase
    end

    p_tc_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> pend);
    p_rd_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_SEL && !tc_evt) |=> !pend);
    p_sel_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_SEL) |=> (dout == $past(bus_wdata[7:4])));
endmodule

// File: rtl/evt_timer24.sv
// Module: top of the 24-bit event timer channel.
// Assumes: tick inputs are single-cycle strobes in the clk domain.
module evt_timer24
    import tmr24_pkg::*;
#(
    parameter int CW        = 24,
    parameter int DW        = 16,
    parameter int TIMER_IDX = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          osc_tick,
    input  logic          t1_out,
    input  logic          eoc_pulse,
    input  logic          eos_pulse,
    output logic          tc_out,
    output logic          irq,
    output logic [3:0]    dout
);
    logic [CW-1:0] cnt, reload;
    logic          running, tc_evt, gate, hi_wr, data_wr, tick;
    logic [1:0]    clk_sel;
    cmode_e        cmode;
    func_e         func;

    tmr24_regs #(.CW(CW), .DW(DW), .TIMER_IDX(TIMER_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .running(running), .tc_evt(tc_evt), .gate(gate),
        .cmode(cmode), .clk_sel(clk_sel), .func(func), .reload(reload),
        .hi_wr(hi_wr), .data_wr(data_wr), .irq(irq), .dout(dout)
    );

    tmr24_clksel #(.NSRC(4)) u_clksel (
        .src({eos_pulse, eoc_pulse, t1_out, osc_tick}),
        .sel(clk_sel), .tick(tick)
    );

    tmr24_core #(.CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .cmode(cmode),
        .func(func), .reload(reload), .hi_wr(hi_wr), .data_wr(data_wr),
        .cnt(cnt), .running(running), .tc_evt(tc_evt), .tc_out(tc_out)
    );
endmodule

// File: tb/evt_timer24_test.sv
// Bench: directed corner cases plus seeded random runs against a model.
module evt_timer24_test;
    localparam int CLK_PERIOD = 10;
    localparam int GATE_ON = 1 << 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  src = '0;
    logic        tc_out, irq;
    logic [3:0]  dout;

    int checks = 0;
    int errors = 0;
    logic [15:0] rv;
    logic [23:0] cv;

    // model state
    int m_cnt, m_reff, m_mode;
    bit m_run, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer24 uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .osc_tick(src[0]), .t1_out(src[1]), .eoc_pulse(src[2]),
        .eos_pulse(src[3]), .tc_out(tc_out), .irq(irq), .dout(dout)
    );

    function automatic int reff(int rl);
        return (rl < 2) ? 2 : rl;
    endfunction

    // expected count after one accepted tick (rate reloads, others stop)
    function automatic int next_cnt(int c, int mode, int r);
        if (c == 1) return (mode == 1) ? r : 0;
        return c - 1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic tick(int s);
        @(negedge clk);
        src[s] = 1'b1;
        @(posedge clk); #1;
        src = '0;
    endtask

    task automatic rd_count(output logic [23:0] v);
        logic [15:0] lo, hi;
        wr(3'd3, 16'h0002);
        rd(3'd4, lo);
        wr(3'd3, 16'h0003);
        rd(3'd4, hi);
        v = {hi[7:0], lo};
    endtask

    task automatic setup(int mode, int fn, int cs, int ien, int rl);
        wr(3'd0, 16'h0);
        wr(3'd1, 16'(mode << 4));
        wr(3'd2, 16'((cs << 6) | (fn << 4) | (ien << 2)));
        wr(3'd3, 16'h0002);
        wr(3'd4, 16'(rl & 16'hffff));
        wr(3'd3, 16'h0003);
        wr(3'd4, 16'((rl >> 16) & 8'hff));
        wr(3'd0, 16'(GATE_ON));
        m_reff = reff(rl); m_cnt = m_reff; m_run = 1; m_mode = mode;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd5, rv); chk("R1 status", rv, 0);
        chk("R1 tc_out", tc_out, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dout", dout, 0);
        rd_count(cv); chk("R1 count", cv, 0);

        // R2 select register drives outputs and reads back
        wr(3'd3, 16'h00A2);
        chk("R2 dout", dout, 4'hA);
        rd(3'd3, rv); chk("R2 readback", rv, 16'h00A2);
        wr(3'd3, 16'h0002);

        // R3 / R5 / R10 rate mode with interrupt enabled
        setup(1, 0, 0, 1, 5);
        rd_count(cv); chk("R3 load", cv, 5);
        repeat (4) tick(0);
        rd_count(cv); chk("R5 count before tc", cv, 1);
        rd(3'd5, rv); chk("R10 no pend yet", rv[12], 0);
        tick(0);
        chk("R5 tc pulse", tc_out, 1);
        chk("R10 irq", irq, 1);
        @(posedge clk); #1;
        chk("R5 pulse one cycle", tc_out, 0);
        rd_count(cv); chk("R5 reloaded", cv, 5);
        rd(3'd5, rv); chk("R10 pend bit12", rv[12], 1);
        rd(3'd3, rv);
        rd(3'd5, rv); chk("R11 cleared", rv[12], 0);
        chk("R11 irq low", irq, 0);

        // R10 interrupt disabled keeps irq low
        setup(1, 0, 0, 0, 2);
        repeat (2) tick(0);
        rd(3'd5, rv); chk("R10 pend no ien", rv[12], 1);
        chk("R10 irq masked", irq, 0);
        rd(3'd3, rv);

        // R4 small reloads
        setup(1, 0, 0, 0, 1);
        rd_count(cv); chk("R4 reload 1", cv, 2);
        setup(1, 0, 0, 0, 0);
        rd_count(cv); chk("R4 reload 0", cv, 2);

        // R6 mode code 0 holds output
        setup(0, 0, 0, 0, 3);
        repeat (3) tick(0);
        chk("R6 out high", tc_out, 1);
        repeat (2) tick(0);
        chk("R6 out held", tc_out, 1);
        rd_count(cv); chk("R6 stopped", cv, 0);

        // R7 code 2 restarts on high-half write
        setup(2, 0, 0, 0, 2);
        repeat (2) tick(0);
        chk("R7 pulse", tc_out, 1);
        tick(0);
        chk("R7 pulse ended", tc_out, 0);
        rd_count(cv); chk("R7 stopped", cv, 0);
        wr(3'd3, 16'h0003); wr(3'd4, 16'h0000);
        rd_count(cv); chk("R7 strobe restart", cv, 2);
        // R7 code 3 ignores the strobe, needs gate edge
        setup(3, 0, 0, 0, 2);
        repeat (2) tick(0);
        wr(3'd3, 16'h0003); wr(3'd4, 16'h0000);
        rd_count(cv); chk("R7 code3 no strobe", cv, 0);
        wr(3'd0, 16'h0); wr(3'd0, 16'(GATE_ON));
        rd_count(cv); chk("R7 code3 gate edge", cv, 2);

        // R8 clock source selection
        setup(1, 0, 2, 0, 10);
        tick(0); tick(1); tick(3);
        rd_count(cv); chk("R8 others ignored", cv, 10);
        tick(2);
        rd_count(cv); chk("R8 eoc counts", cv, 9);

        // R9 gate cleared holds count
        wr(3'd0, 16'h0);
        repeat (3) tick(2);
        rd_count(cv); chk("R9 held", cv, 9);

        // R12 snapshot on low-half read
        setup(1, 0, 0, 0, 24'h010002);
        repeat (2) tick(0);
        wr(3'd3, 16'h0002); rd(3'd4, rv); chk("R12 low", rv, 0);
        tick(0);
        wr(3'd3, 16'h0003); rd(3'd4, rv); chk("R12 snapshot high", rv, 1);
        rd_count(cv); chk("R12 live", cv, 24'h00FFFF);

        // R13 watchdog kick vs timer function
        setup(1, 2, 0, 0, 10);
        repeat (4) tick(0);
        wr(3'd3, 16'h0002); wr(3'd4, 16'd12);
        rd_count(cv); chk("R13 kick", cv, 12);
        setup(1, 0, 0, 0, 10);
        repeat (4) tick(0);
        wr(3'd3, 16'h0002); wr(3'd4, 16'd12);
        rd_count(cv); chk("R13 timer no kick", cv, 6);

        // R11 terminal count in same cycle as clearing read
        setup(1, 0, 0, 1, 2);
        tick(0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'd3; src[0] = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; src = '0;
        rd(3'd5, rv); chk("R11 set wins", rv[12], 1);
        rd(3'd3, rv);

        // random runs against the model (R3 R5 R6 R7 R8 R10)
        for (int it = 0; it < 30; it++) begin
            int md, cs, ie, rl, n;
            md = $urandom % 4; cs = $urandom % 4; ie = $urandom % 2;
            rl = $urandom % 40; n = $urandom % 45;
            setup(md, $urandom % 2, cs, ie, rl);
            m_pend = 0;
            for (int k = 0; k < n; k++) begin
                if ($urandom % 4 == 0) tick((cs + 1 + ($urandom % 3)) % 4);
                tick(cs);
                if (m_run) begin
                    if (m_cnt == 1) begin
                        m_pend = 1;
                        if (m_mode != 1) m_run = 0;
                    end
                    m_cnt = next_cnt(m_cnt, m_mode, m_reff);
                end
            end
            rd(3'd5, rv); chk("R10 random pend", rv[12], m_pend);
            chk("R10 random irq", irq, m_pend & ie);
            rd_count(cv); chk("R5 random count", cv, m_cnt);
            rd(3'd3, rv);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule